// File: doc/BRIEF.md
# Remainder-Based Quotient Rounding Selector

This block performs the last step of a multiplicative divide or square root. It receives a trial significand that carries one bit more than the target precision, the guard bit. The trial is known to lie within half a unit in the last place (ulp) of the exact result at target precision. It also receives two status bits from a back-multiplied remainder: the sign of b·q − a and a flag that is set when that remainder is zero. From these it picks one of three candidates, all formed in parallel: the trial truncated to target precision, that value plus one ulp, or that value minus one ulp. No sticky bits are involved.

The rounding mode, the sign of the final result and a precision selector complete the inputs. The chosen significand is registered and appears left-aligned, with every bit below the target LSB cleared. Next to it comes a flag that feeds the condition code and tells whether the magnitude was rounded up. Forming the remainder and handling exponent overflow are left to neighbouring logic.

Top module: `rem_round_sel`

## Requirements
- R1: Every cycle in which `in_valid` is high yields a result one clock edge later, with `out_valid` high. `out_valid` is low in the cycle after any cycle in which `in_valid` is low.
- R2: `prec` selects the target width p: 0 gives 24 bits, 1 gives 53, 2 gives 64 and 3 gives 68. The trial's top p bits, `trial[68:69-p]`, are the truncated value, and `trial[68-p]` is the guard bit. Trial bits below the guard bit are ignored. `sig_out` holds the p-bit result in `sig_out[67:68-p]`, and every lower bit of `sig_out` is zero.
- R3: `rem_neg` is the sign of b·q − a. With `rem_zero` low, `rem_neg` = 1 means the exact value lies above the trial, and `rem_neg` = 0 means it lies below the trial. With `rem_zero` high, the trial is exact.
- R4: `mode` 0 rounds to nearest with ties to even. With the guard bit at 0, the result is truncated. With the guard bit at 1, the result is incremented when the exact value lies above the trial and truncated when it lies below. On an exact tie, it is incremented only if the truncated LSB is 1.
- R5: `mode` 1 rounds toward zero. With the guard bit at 0 and the exact value below the trial, the result is decremented. In all other cases it is truncated.
- R6: `mode` 2 rounds toward +infinity. For a positive result (`res_neg` = 0), the result is incremented when the guard bit is 1 or the exact value lies above the trial, and truncated otherwise. For a negative result, it is decremented when the guard bit is 0 and the exact value lies below the trial, and truncated otherwise.
- R7: `mode` 3 rounds toward −infinity, as the mirror of R6. A negative result takes the increment rule of R6, and a positive result takes the decrement rule.
- R8: `round_up` is 1 exactly when the result exceeds the exact value truncated to p bits. The exact value truncated is the truncated trial, less one ulp when the guard bit is 0 and the exact value lies below the trial. An increment always sets the flag, and a decrement never does.
- R9: A carry out of the top bit on increment, or a borrow on decrement, is discarded. The result wraps modulo 2^68.
- R10: While `rst_n` is low, `out_valid`, `sig_out` and `round_up` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inputs carry a request this cycle |
| trial | input | 69 | Trial significand, left-aligned, guard bit after the top p bits |
| prec | input | 2 | Target precision select |
| mode | input | 2 | Rounding mode select |
| res_neg | input | 1 | Sign of the final result |
| rem_neg | input | 1 | Sign bit of b·q − a |
| rem_zero | input | 1 | Remainder is exactly zero |
| out_valid | output | 1 | `sig_out` and `round_up` are valid |
| sig_out | output | 68 | Rounded significand, left-aligned, low bits cleared |
| round_up | output | 1 | Magnitude was rounded up |

## Verification
The assertions assume the remainder status is consistent with the trial. They assume that `rem_zero` is never raised together with `rem_neg`. They also assume the trial's error is under half an ulp, so that exactly one of below, exact and above holds. The stimulus meets this by choosing the exact value's position first: a quarter ulp below, on, or a quarter ulp above the trial. It then derives `rem_neg` and `rem_zero` from that position, and fills the ignored low trial bits with random values. The expected result comes from rounding that chosen position directly in each mode.

// File: rtl/rem_round_sel.sv
module rem_round_sel #(
  parameter int SIG_W = 68,
  parameter int P_0   = 24,
  parameter int P_1   = 53,
  parameter int P_2   = 64,
  parameter int P_3   = 68
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [SIG_W:0]   trial,
  input  logic [1:0]       prec,
  input  logic [1:0]       mode,
  input  logic             res_neg,
  input  logic             rem_neg,
  input  logic             rem_zero,
  output logic             out_valid,
  output logic [SIG_W-1:0] sig_out,
  output logic             round_up
);
  localparam logic [SIG_W-1:0] ONES = '1;
  localparam logic [SIG_W-1:0] ONE  = 1;

  logic [7:0]       pw;
  logic [SIG_W-1:0] keep, ulp, trunc, plus, minus, pick;
  logic             guard, lsb, above, below, up, dn;

  always_comb begin
    case (prec)
      2'd0:    pw = 8'(P_0);
      2'd1:    pw = 8'(P_1);
      2'd2:    pw = 8'(P_2);
      default: pw = 8'(P_3);
    endcase
  end

  assign keep  = ~(ONES >> pw);
  assign ulp   = ONE << (SIG_W - int'(pw));
  assign guard = |(trial & {1'b0, ulp});
  assign trunc = trial[SIG_W:1] & keep;
  assign lsb   = |(trunc & ulp);
  assign above = rem_neg & ~rem_zero;
  assign below = ~rem_neg & ~rem_zero;

  assign plus  = trunc + ulp;
  assign minus = trunc - ulp;

  always_comb begin
    up = 1'b0;
    dn = 1'b0;
    case (mode)
      2'd0: up = guard & (above | (rem_zero & lsb));
      2'd1: dn = ~guard & below;
      2'd2: if (!res_neg) up = guard | above; else dn = ~guard & below;
      default: if (res_neg) up = guard | above; else dn = ~guard & below;
    endcase
  end

  assign pick = up ? plus : (dn ? minus : trunc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      sig_out   <= '0;
      round_up  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        sig_out  <= pick;
        round_up <= up | (~dn & ~guard & below);
      end
    end
  end
endmodule

module rem_round_chk #(
  parameter int SIG_W = 68,
  parameter int P_0   = 24,
  parameter int P_1   = 53,
  parameter int P_2   = 64,
  parameter int P_3   = 68
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [SIG_W:0]   trial,
  input logic [1:0]       prec,
  input logic [1:0]       mode,
  input logic             rem_neg,
  input logic             rem_zero,
  input logic             out_valid,
  input logic [SIG_W-1:0] sig_out,
  input logic             round_up
);
  localparam logic [SIG_W-1:0] ONES = '1;
  localparam logic [SIG_W-1:0] ONE  = 1;

  function automatic int width_of(input logic [1:0] s);
    case (s)
      2'd0: return P_0;
      2'd1: return P_1;
      2'd2: return P_2;
      default: return P_3;
    endcase
  endfunction

  logic [SIG_W-1:0] lo_q, ulp_q, tr_q;
  logic [1:0]       mode_q;
  logic             tie_q, exact_q;
  logic [SIG_W-1:0] lo_n, ulp_n;
  logic             g_n;

  assign lo_n  = ONES >> width_of(prec);
  assign ulp_n = ONE << (SIG_W - width_of(prec));
  assign g_n   = |(trial & {1'b0, ulp_n});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0; ulp_q <= '0; tr_q <= '0; mode_q <= '0;
      tie_q <= 1'b0; exact_q <= 1'b0;
    end else if (in_valid) begin
      lo_q    <= lo_n;
      ulp_q   <= ulp_n;
      tr_q    <= trial[SIG_W:1] & ~lo_n;
      mode_q  <= mode;
      tie_q   <= g_n & rem_zero;
      exact_q <= ~g_n & rem_zero;
    end
  end

  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_low_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((sig_out & lo_q) == '0));
  p_tie_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mode_q == 2'd0 && tie_q) |-> ((sig_out & ulp_q) == '0));
  p_rz_no_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mode_q == 2'd1) |-> !round_up);
  p_exact_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && exact_q) |-> (!round_up && sig_out == tr_q));
  p_reset_quiet_r10: assert property (@(posedge clk)
    $past(!rst_n) |-> (!out_valid && !round_up));
endmodule

bind rem_round_sel rem_round_chk #(.SIG_W(SIG_W), .P_0(P_0), .P_1(P_1), .P_2(P_2), .P_3(P_3)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .trial(trial), .prec(prec),
  .mode(mode), .rem_neg(rem_neg), .rem_zero(rem_zero), .out_valid(out_valid),
  .sig_out(sig_out), .round_up(round_up));

// File: tb/sim_rem_round_sel.sv
`timescale 1ns/1ps
module sim_rem_round_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [68:0] trial = '0;
  logic [1:0]  prec = '0, mode = '0;
  logic        res_neg = 1'b0, rem_neg = 1'b0, rem_zero = 1'b0;
  logic        out_valid, round_up;
  logic [67:0] sig_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rem_round_sel u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .trial(trial),
    .prec(prec), .mode(mode), .res_neg(res_neg), .rem_neg(rem_neg), .rem_zero(rem_zero),
    .out_valid(out_valid), .sig_out(sig_out), .round_up(round_up));

  function automatic int pbits(input logic [1:0] s);
    case (s) 2'd0: return 24; 2'd1: return 53; 2'd2: return 64; default: return 68; endcase
  endfunction

  // off: -1 exact value a quarter ulp below trial, 0 exact, +1 above
  function automatic logic [68:0] model(input logic [68:0] q, input logic [1:0] s,
      input logic [1:0] m, input logic neg, input int off);
    int p = pbits(s);
    logic [67:0] t = '0;
    logic [67:0] u = '0;
    int g, y, fl, fr, k;
    logic even;
    for (int i = 0; i < p; i++) t[67-i] = q[68-i];
    u[68-p] = 1'b1;
    g  = int'(q[68-p]);
    y  = 2*g + off;
    fl = (y < 0) ? -1 : 0;
    fr = y - 4*fl;
    even = ~t[68-p];
    case (m)
      2'd0: k = (fr < 2) ? fl : (fr > 2) ? fl + 1 : (even ? fl : fl + 1);
      2'd1: k = fl;
      2'd2: k = neg ? fl : fl + ((fr != 0) ? 1 : 0);
      default: k = neg ? fl + ((fr != 0) ? 1 : 0) : fl;
    endcase
    if (k > 0) t = t + u; else if (k < 0) t = t - u;
    return {(k > fl) ? 1'b1 : 1'b0, t};
  endfunction

  task automatic run(input logic [68:0] q, input logic [1:0] s, input logic [1:0] m,
      input logic neg, input int off, input string tag);
    logic [68:0] e;
    @(negedge clk);
    trial = q; prec = s; mode = m; res_neg = neg;
    rem_zero = (off == 0); rem_neg = (off > 0);
    in_valid = 1'b1;
    e = model(q, s, m, neg, off);
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (!out_valid || sig_out !== e[67:0] || round_up !== e[68]) begin
      errors++;
      $display("FAIL %s: got v=%0b sig=%h up=%0b expected v=1 sig=%h up=%0b",
               tag, out_valid, sig_out, round_up, e[67:0], e[68]);
    end
  endtask

  function automatic string mtag(input logic [1:0] m);
    case (m) 2'd0: return "R4"; 2'd1: return "R5"; 2'd2: return "R6"; default: return "R7"; endcase
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [68:0] q;
    int unsigned sd;
    sd = $urandom(32'd2718);
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || sig_out !== '0 || round_up !== 1'b0) begin
      errors++;
      $display("FAIL R10: got v=%0b sig=%h up=%0b expected 0 0 0", out_valid, sig_out, round_up);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: idle out_valid got %0b expected 0", out_valid);
    end

    // R4 ties: truncated LSB even keeps, odd increments (double precision)
    q = '0; q[68] = 1'b1; q[68-53] = 1'b1;
    run(q, 2'd1, 2'd0, 1'b0, 0, "R4 tie even");
    q[69-53] = 1'b1;
    run(q, 2'd1, 2'd0, 1'b0, 0, "R4 tie odd");
    // R9 wrap on increment and decrement, R2 ignored low bits
    q = '1;
    run(q, 2'd3, 2'd2, 1'b0, 1, "R9 carry wrap");
    q = '0;
    run(q, 2'd0, 2'd1, 1'b0, -1, "R9 borrow wrap");
    q = '0; q[68] = 1'b1; q[30:0] = '1; q[68-24] = 1'b0;
    run(q, 2'd0, 2'd0, 1'b0, 0, "R2 low bits ignored");
    // R3 remainder sign sense, R8 flag on truncate with below
    q = '0; q[68] = 1'b1; q[60] = 1'b1;
    run(q, 2'd0, 2'd0, 1'b0, -1, "R3 R8 below guard0");
    q[68-24] = 1'b1;
    run(q, 2'd0, 2'd0, 1'b0, 1, "R3 above guard1");
    run(q, 2'd0, 2'd0, 1'b0, -1, "R3 below guard1");

    for (int n = 0; n < 4000; n++) begin
      logic [1:0] s, m;
      logic neg;
      int off;
      q = {$urandom, $urandom, $urandom};
      s = 2'($urandom); m = 2'($urandom); neg = 1'($urandom);
      off = int'($urandom % 3) - 1;
      run(q, s, m, neg, off, {mtag(m), " R8 R2 random"});
    end
    checks++;
    @(negedge clk);
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: trailing out_valid got %0b expected 0", out_valid);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule